// File: doc/BRIEF.md
# Nibble Rotate and Flag Clear Execution Slice

This block is one execution slice of a 4-bit microcontroller core. It recognises two 12-bit instructions. The first rotates one of four register-file nibbles right by one place through the carry flag. The second clears selected flags by ANDing the flag nibble with a 4-bit immediate taken from the opcode. Every other opcode is reported as illegal and has no other effect.

The surrounding core presents an opcode with a one-cycle start strobe, together with the four register nibbles and the flag nibble. Operands are captured on the cycle the instruction is accepted. The slice stays busy for the instruction's fixed length. On the final cycle it raises a one-cycle done pulse and, in the same cycle, presents the write-back value with its enable and the updated flag nibble with its write enable.

Top module: `rfm_exec_unit`

## Requirements
- R1: Opcodes 0xE8C through 0xE8F are the rotate instruction. Opcode bits [1:0] select the source and destination nibble: 00 selects reg_a_i, 01 selects reg_b_i, 10 selects reg_mx_i and 11 selects reg_my_i. The same code appears on wb_sel_o.
- R2: A rotate writes back {C, d3, d2, d1}, where d is the source nibble and C is flag bit 0. The new flag bit 0 equals the old d0. Flag bits [3:1] keep their captured values.
- R3: A rotate lasts 5 cycles, counting the start cycle as cycle 1. done_o, wb_en_o and flags_we_o are high in cycle 5 only.
- R4: Opcodes 0xF50 through 0xF5F are the flag-clear instruction. The flag nibble is ordered I (bit 3), D (bit 2), Z (bit 1), C (bit 0). The new flags are the old flags ANDed with opcode bits [3:0]. wb_en_o stays low.
- R5: A flag-clear lasts 7 cycles, counting the start cycle as cycle 1. done_o and flags_we_o are high in cycle 7 only.
- R6: busy_o is high from the cycle after an accepted start through the done cycle. It is low in the cycle that follows.
- R7: A start with any other opcode raises illegal_o in the same cycle. It starts nothing, leaves busy_o low and raises neither write enable.
- R8: A start while busy_o is high is ignored. The running instruction completes with its own result and timing, and no second done follows.
- R9: Register and flag inputs are captured when the instruction is accepted. Changes to them during busy do not alter the result.
- R10: While rst_ni is low and after its release, busy_o, done_o, wb_en_o, flags_we_o and illegal_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Instruction start strobe |
| opcode_i | input | 12 | Instruction word |
| reg_a_i | input | 4 | Register A contents |
| reg_b_i | input | 4 | Register B contents |
| reg_mx_i | input | 4 | Register MX contents |
| reg_my_i | input | 4 | Register MY contents |
| flags_i | input | 4 | Current flags {I,D,Z,C} |
| wb_sel_o | output | 2 | Write-back register select |
| wb_data_o | output | 4 | Write-back value |
| wb_en_o | output | 1 | Write-back enable, one cycle |
| flags_o | output | 4 | Updated flags {I,D,Z,C} |
| flags_we_o | output | 1 | Flag write enable, one cycle |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | Completion pulse |
| illegal_o | output | 1 | Unrecognised opcode at start |

## Verification
The checker assumes that start_i is a single-cycle strobe and that opcode_i and the register inputs are valid whenever start_i is high. Beyond the accept cycle, it assumes nothing about the inputs, because operands are captured at accept. The stimulus raises start only for one cycle, at the falling edge. It deliberately scrambles the register and flag inputs while busy, and it injects starts in the middle of an instruction. Opcodes are drawn from both legal ranges and from the rest of the 12-bit space, so the illegal path also stays inside these assumptions.

// File: rtl/rfm_pkg.sv
package rfm_pkg;
  localparam int NIB_W = 4;
  localparam int OPC_W = 12;
  localparam int SEL_W = 2;

  localparam logic [9:0] ROT_PREFIX  = 10'b1110_1000_11;
  localparam logic [7:0] MASK_PREFIX = 8'b1111_0101;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ROT  = 2'd1,
    OP_MASK = 2'd2
  } op_e;

  typedef struct packed {
    op_e              kind;
    logic [SEL_W-1:0] sel;
    logic [NIB_W-1:0] imm;
  } dec_t;
endpackage

// File: rtl/rfm_decode.sv
module rfm_decode
  import rfm_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  output dec_t             dec_o
);
  always_comb begin
    dec_o      = '0;
    dec_o.kind = OP_NONE;
    dec_o.sel  = opcode_i[SEL_W-1:0];
    dec_o.imm  = opcode_i[NIB_W-1:0];
    if (opcode_i[OPC_W-1:2] == ROT_PREFIX)
      dec_o.kind = OP_ROT;
    else if (opcode_i[OPC_W-1:4] == MASK_PREFIX)
      dec_o.kind = OP_MASK;
  end
endmodule

// File: rtl/rfm_alu.sv
module rfm_alu
  import rfm_pkg::*;
(
  input  op_e              kind_i,
  input  logic [NIB_W-1:0] src_i,
  input  logic [NIB_W-1:0] flags_i,
  input  logic [NIB_W-1:0] imm_i,
  output logic [NIB_W-1:0] data_o,
  output logic [NIB_W-1:0] flags_o
);
  always_comb begin
    data_o  = src_i;
    flags_o = flags_i;
    unique case (kind_i)
      OP_ROT: begin
        data_o  = {flags_i[0], src_i[NIB_W-1:1]};
        flags_o = {flags_i[NIB_W-1:1], src_i[0]};
      end
      OP_MASK: flags_o = flags_i & imm_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/rfm_seq.sv
module rfm_seq
  import rfm_pkg::*;
#(
  parameter int ROT_CYC  = 5,
  parameter int MASK_CYC = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic accept_i,
  input  op_e  kind_i,
  output logic busy_o,
  output logic done_o
);
  localparam int MAX_CYC = (ROT_CYC > MASK_CYC) ? ROT_CYC : MASK_CYC;
  localparam int CNT_W   = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end else if (accept_i) begin
      busy_q <= 1'b1;
      cnt_q  <= (kind_i == OP_ROT) ? CNT_W'(ROT_CYC - 2) : CNT_W'(MASK_CYC - 2);
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);
endmodule

// File: rtl/rfm_exec_unit.sv
module rfm_exec_unit
  import rfm_pkg::*;
#(
  parameter int ROT_CYC  = 5,
  parameter int MASK_CYC = 7
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [11:0] opcode_i,
  input  logic [3:0]  reg_a_i,
  input  logic [3:0]  reg_b_i,
  input  logic [3:0]  reg_mx_i,
  input  logic [3:0]  reg_my_i,
  input  logic [3:0]  flags_i,
  output logic [1:0]  wb_sel_o,
  output logic [3:0]  wb_data_o,
  output logic        wb_en_o,
  output logic [3:0]  flags_o,
  output logic        flags_we_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        illegal_o
);
  dec_t             dec;
  logic             accept;
  logic             busy, done;
  logic [NIB_W-1:0] src_sel;
  op_e              kind_q;
  logic [SEL_W-1:0] sel_q;
  logic [NIB_W-1:0] imm_q, src_q, flg_q;

  rfm_decode u_dec (.opcode_i(opcode_i), .dec_o(dec));

  always_comb begin
    unique case (dec.sel)
      2'd0:    src_sel = reg_a_i;
      2'd1:    src_sel = reg_b_i;
      2'd2:    src_sel = reg_mx_i;
      default: src_sel = reg_my_i;
    endcase
  end

  assign accept = start_i && !busy && (dec.kind != OP_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q <= OP_NONE;
      sel_q  <= '0;
      imm_q  <= '0;
      src_q  <= '0;
      flg_q  <= '0;
    end else if (accept) begin
      kind_q <= dec.kind;
      sel_q  <= dec.sel;
      imm_q  <= dec.imm;
      src_q  <= src_sel;
      flg_q  <= flags_i;
    end
  end

  rfm_seq #(.ROT_CYC(ROT_CYC), .MASK_CYC(MASK_CYC)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .kind_i  (dec.kind),
    .busy_o  (busy),
    .done_o  (done)
  );

  rfm_alu u_alu (
    .kind_i (kind_q),
    .src_i  (src_q),
    .flags_i(flg_q),
    .imm_i  (imm_q),
    .data_o (wb_data_o),
    .flags_o(flags_o)
  );

  assign wb_sel_o   = sel_q;
  assign wb_en_o    = done && (kind_q == OP_ROT);
  assign flags_we_o = done;
  assign busy_o     = busy;
  assign done_o     = done;
  assign illegal_o  = start_i && !busy && (dec.kind == OP_NONE);
endmodule

// File: rtl/rfm_exec_unit_chk.sv
module rfm_exec_unit_chk #(
  parameter int ROT_CYC  = 5,
  parameter int MASK_CYC = 7
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic [11:0] opcode_i,
  input logic [3:0]  reg_a_i,
  input logic [3:0]  reg_b_i,
  input logic [3:0]  reg_mx_i,
  input logic [3:0]  reg_my_i,
  input logic [3:0]  flags_i,
  input logic [1:0]  wb_sel_o,
  input logic [3:0]  wb_data_o,
  input logic        wb_en_o,
  input logic [3:0]  flags_o,
  input logic        flags_we_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        illegal_o
);
  logic       is_rot, is_msk, acc;
  logic [7:0] elapsed_q, exp_q;
  logic       rot_q;
  logic [3:0] src_q, fl_q, imm_q;
  logic [3:0] src_c;

  assign is_rot = (opcode_i[11:2] == 10'h3A3);
  assign is_msk = (opcode_i[11:4] == 8'hF5);
  assign acc    = start_i && !busy_o && (is_rot || is_msk);

  always_comb begin
    case (opcode_i[1:0])
      2'd0:    src_c = reg_a_i;
      2'd1:    src_c = reg_b_i;
      2'd2:    src_c = reg_mx_i;
      default: src_c = reg_my_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      elapsed_q <= '0; exp_q <= '0; rot_q <= 1'b0;
      src_q <= '0; fl_q <= '0; imm_q <= '0;
    end else if (acc) begin
      elapsed_q <= 8'd1;
      exp_q     <= is_rot ? 8'(ROT_CYC) : 8'(MASK_CYC);
      rot_q     <= is_rot;
      src_q     <= src_c;
      fl_q      <= flags_i;
      imm_q     <= opcode_i[3:0];
    end else if (busy_o) begin
      elapsed_q <= elapsed_q + 8'd1;
    end
  end

  // R3
  done_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (elapsed_q == exp_q - 8'd1));
  // R6
  done_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  // R6
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
  // R6
  busy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  // R7
  illegal_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (!wb_en_o && !flags_we_o && !busy_o));
  // R2
  rot_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && rot_q) |-> (wb_en_o && wb_data_o == {fl_q[0], src_q[3:1]}
                          && flags_o == {fl_q[3:1], src_q[0]}));
  // R4
  mask_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !rot_q) |-> (!wb_en_o && flags_o == (fl_q & imm_q)));
  // R8
  sel_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> $stable(wb_sel_o));
endmodule

bind rfm_exec_unit rfm_exec_unit_chk #(.ROT_CYC(ROT_CYC), .MASK_CYC(MASK_CYC)) chk_i (.*);

// File: tb/rfm_exec_unit_tb_top.sv
module rfm_exec_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] opcode = '0;
  logic [3:0]  ra = '0, rb = '0, rmx = '0, rmy = '0, fl = '0;
  logic [1:0]  wb_sel;
  logic [3:0]  wb_data, flags_out;
  logic        wb_en, flags_we, busy, done, illegal;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  rfm_exec_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(opcode),
    .reg_a_i(ra), .reg_b_i(rb), .reg_mx_i(rmx), .reg_my_i(rmy), .flags_i(fl),
    .wb_sel_o(wb_sel), .wb_data_o(wb_data), .wb_en_o(wb_en),
    .flags_o(flags_out), .flags_we_o(flags_we), .busy_o(busy),
    .done_o(done), .illegal_o(illegal)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int op_kind(input logic [11:0] op);
    if (op >= 12'hE8C && op <= 12'hE8F) return 1;
    if (op >= 12'hF50 && op <= 12'hF5F) return 2;
    return 0;
  endfunction

  function automatic logic [3:0] pick(input logic [1:0] s, input logic [3:0] a,
      input logic [3:0] b, input logic [3:0] x, input logic [3:0] y);
    case (s)
      2'd0: return a;
      2'd1: return b;
      2'd2: return x;
      default: return y;
    endcase
  endfunction

  task automatic scramble();
    ra = 4'($urandom); rb = 4'($urandom); rmx = 4'($urandom);
    rmy = 4'($urandom); fl = 4'($urandom);
  endtask

  // intrude: issue a mask start in cycle 3 of the running op (R8)
  task automatic run_op(input logic [11:0] op, input logic [3:0] a, input logic [3:0] b,
      input logic [3:0] x, input logic [3:0] y, input logic [3:0] f, input bit intrude);
    int kind, n;
    logic [3:0] src, e_data, e_flags;
    kind = op_kind(op);
    n = (kind == 1) ? 5 : 7;
    src = pick(op[1:0], a, b, x, y);
    e_data = {f[0], src[3:1]};
    e_flags = (kind == 1) ? {f[3:1], src[0]} : (f & op[3:0]);
    @(negedge clk);
    opcode = op; ra = a; rb = b; rmx = x; rmy = y; fl = f; start = 1'b1;
    #1;
    if (kind == 0) begin
      chk(illegal == 1'b1, "R7 illegal pulse", illegal, 1);
      chk(!wb_en && !flags_we, "R7 no write", {wb_en, flags_we}, 0);
      @(negedge clk); start = 1'b0; #1;
      chk(busy == 1'b0, "R7 not busy", busy, 0);
      chk(illegal == 1'b0, "R7 pulse width", illegal, 0);
      return;
    end
    chk(illegal == 1'b0, "R1 legal no illegal", illegal, 0);
    @(negedge clk); start = 1'b0; scramble();
    for (int c = 2; c <= n; c++) begin
      if (intrude && c == 3) begin start = 1'b1; opcode = 12'hF50; end
      if (intrude && c == 4) start = 1'b0;
      #1;
      if (c < n) begin
        chk(busy && !done && !wb_en && !flags_we, "R6 busy no done",
            {busy, done, wb_en, flags_we}, 4'b1000);
        if (intrude) chk(illegal == 1'b0, "R8 no illegal while busy", illegal, 0);
        @(negedge clk);
        scramble();
      end else begin
        chk(done && busy, (kind == 1) ? "R3 done at cycle 5" : "R5 done at cycle 7",
            {done, busy}, 2'b11);
        chk(flags_we == 1'b1, "R3/R5 flags_we", flags_we, 1);
        chk(flags_out == e_flags, (kind == 1) ? "R2 flags" : "R4 flags",
            flags_out, e_flags);
        if (kind == 1) begin
          chk(wb_en == 1'b1, "R3 wb_en", wb_en, 1);
          chk(wb_data == e_data, "R2 data R9", wb_data, e_data);
          chk(wb_sel == op[1:0], "R1 sel", wb_sel, op[1:0]);
        end else begin
          chk(wb_en == 1'b0, "R4 no writeback", wb_en, 0);
        end
      end
    end
    @(negedge clk); #1;
    chk(!busy && !done, "R6 busy drops", {busy, done}, 0);
    if (intrude) begin
      for (int k = 0; k < 8; k++) begin
        @(negedge clk); #1;
        chk(!done && !busy, "R8 no second done", {done, busy}, 0);
      end
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !done && !wb_en && !flags_we && !illegal, "R10 in reset",
        {busy, done, wb_en, flags_we, illegal}, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(!busy && !done && !wb_en && !flags_we, "R10 after release",
        {busy, done, wb_en, flags_we}, 0);

    // worked examples: 1010 rot with C=1 -> 1101, C=0; flags 1010 & 0010 -> 0010
    run_op(12'hE8F, 4'h0, 4'h0, 4'h0, 4'hA, 4'b0001, 1'b0);
    run_op(12'hF52, 4'h0, 4'h0, 4'h0, 4'h0, 4'b1010, 1'b0);
    // each selector (R1)
    run_op(12'hE8C, 4'h3, 4'h0, 4'h0, 4'h0, 4'b1110, 1'b0);
    run_op(12'hE8D, 4'h0, 4'h9, 4'h0, 4'h0, 4'b0000, 1'b0);
    run_op(12'hE8E, 4'h0, 4'h0, 4'hF, 4'h0, 4'b1111, 1'b0);
    // mask edges (R4)
    run_op(12'hF50, 4'h0, 4'h0, 4'h0, 4'h0, 4'hF, 1'b0);
    run_op(12'hF5F, 4'h0, 4'h0, 4'h0, 4'h0, 4'hB, 1'b0);
    // range boundaries that are illegal (R7)
    run_op(12'hE8B, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 1'b0);
    run_op(12'hE90, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 1'b0);
    run_op(12'hF4F, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 1'b0);
    run_op(12'hF60, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 1'b0);
    // start during busy (R8)
    run_op(12'hE8D, 4'h0, 4'h6, 4'h0, 4'h0, 4'b0101, 1'b1);
    run_op(12'hF5A, 4'h0, 4'h0, 4'h0, 4'h0, 4'hF, 1'b1);

    for (int i = 0; i < 300; i++) begin
      logic [11:0] op;
      int r;
      r = int'($urandom % 3);
      if (r == 0)      op = 12'hE8C | 12'($urandom % 4);
      else if (r == 1) op = 12'hF50 | 12'($urandom % 16);
      else             op = 12'($urandom);
      run_op(op, 4'($urandom), 4'($urandom), 4'($urandom), 4'($urandom),
             4'($urandom), (op_kind(op) != 0) && (($urandom % 8) == 0));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule